// File: doc/BRIEF.md
# Framed channel sum and timing encoder

The encoder condenses sixteen 12-bit sample channels into a compact trigger stream. Time is cut into frames of eight clock slots, which at a 4 ns clock is a 32 ns frame. Each channel ends every frame as a single byte. The low five bits hold the channel's summed amplitude, scaled down and clipped. The top three bits give the slot in which the channel first crossed its threshold, so hit time survives at full clock resolution even though data leave only once per frame.

A single-cycle sync pulse sets frame alignment: the cycle that carries it is slot 0. A frame cut short by a sync is dropped. After the clock edge that ends a frame's last slot, the frame's sixteen bytes stream out as eight 16-bit words on the next eight cycles, ready for a serializer. The first word carries a start marker. Sixteen bytes per 32 ns is 4 Gb/s of payload.

Top module: `fcenc_top`

## Requirements
- R1: The cycle in which `sync_i` is high is slot 0. Slots then count 0 to 7 and wrap, so a frame spans 8 cycles, until the next sync.
- R2: The frame whose slot 7 falls in cycle T is output in cycles T+1 to T+8. Word k, for k from 0 to 7, holds channel 2k in bits 7:0 and channel 2k+1 in bits 15:8. `valid_o` is high for all eight words, `sof_o` is high only with word 0, and the eight words are contiguous.
- R3: Each channel byte holds the slot code in bits 7:5 and the scaled sum in bits 4:0.
- R4: A sample is a hit when it is strictly greater than `thr_i`. The slot code is the slot of the channel's first hit in the frame, and later hits do not change it.
- R5: The sum field is the total of the channel's hit samples over the frame, shifted right by `shift_i` and saturated at 31.
- R6: A channel with no hit in a frame produces the byte 0x00. This includes samples exactly equal to `thr_i`.
- R7: A sync that arrives before slot 7 discards the open frame. No bytes are ever emitted for that frame, and its samples do not reach the next frame.
- R8: While `rst_ni` is low, `valid_o`, `sof_o` and `word_o` are 0, regardless of the clock.
- R9: Frames that follow each other give an unbroken output stream: word 0 of the next frame comes in the cycle right after word 7 of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one slot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame alignment pulse; marks slot 0 |
| samp_i | input | 192 | 16 channels × 12 bits; channel c at bits 12c+11:12c |
| thr_i | input | 12 | Hit threshold; a hit needs a sample above it |
| shift_i | input | 4 | Right shift applied to the frame sum |
| word_o | output | 16 | Two channel bytes per cycle |
| valid_o | output | 1 | word_o carries frame data |
| sof_o | output | 1 | Marks word 0 of a frame |

## Verification
The bench places hits at the first and last slots, at a sample equal to the threshold, at amplitudes large enough to clip, and with hits whose shifted sum is zero. A design that ties the slot code to the last hit, compares with >=, wraps instead of saturating, or drops the code when the sum shifts to zero would put a wrong byte on the target channel. A frame cut short by a sync is followed by a hit at the new slot 0. A counter that ignores the sync, or that keeps the partial sum, would report slot 4 or an inflated sum. Sixteen channels are swept with odd and even indices, so swapped byte lanes, a misplaced start marker, or a gap between frames show up at once.

// File: rtl/fcenc_pkg.sv
package fcenc_pkg;
  localparam int unsigned N_CH_D      = 16;
  localparam int unsigned SAMP_W_D    = 12;
  localparam int unsigned FRAME_LEN_D = 8;
  localparam int unsigned SUM_W_D     = 5;
endpackage

// File: rtl/fcenc_slot_ctr.sv
module fcenc_slot_ctr #(
  parameter int unsigned FRAME_LEN = 8,
  localparam int unsigned SLOT_W = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);

  logic [SLOT_W-1:0] cnt_q;

  assign slot_o = sync_i ? '0 : cnt_q;
  assign last_o = (slot_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else              cnt_q <= slot_o + 1'b1;
  end

  // R1: counter steps by one between syncs
  a_r1_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && cnt_q != LAST) |=> cnt_q == SLOT_W'($past(cnt_q) + 1'b1));
  // R1: sync cycle is slot 0, so the next cycle is slot 1
  a_r1_sync_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> cnt_q == SLOT_W'(1));
endmodule

// File: rtl/fcenc_chan.sv
module fcenc_chan #(
  parameter int unsigned SAMP_W  = 12,
  parameter int unsigned SLOT_W  = 3,
  parameter int unsigned SUM_W   = 5,
  localparam int unsigned ACC_W   = SAMP_W + SLOT_W,
  localparam int unsigned SHIFT_W = $clog2(ACC_W),
  localparam int unsigned BYTE_W  = SLOT_W + SUM_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [SAMP_W-1:0]  samp_i,
  input  logic [SAMP_W-1:0]  thr_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [BYTE_W-1:0]  byte_o
);
  logic [ACC_W-1:0]  acc_q, acc_cur, acc_nx, scaled;
  logic [SLOT_W-1:0] first_q, first_cur, first_nx;
  logic              seen_q, seen_cur, seen_nx, hit, start;
  logic [SUM_W-1:0]  sat;

  assign hit   = samp_i > thr_i;
  assign start = (slot_i == '0);

  always_comb begin
    acc_cur   = start ? '0 : acc_q;
    seen_cur  = start ? 1'b0 : seen_q;
    first_cur = start ? '0 : first_q;
    acc_nx    = acc_cur + (hit ? ACC_W'(samp_i) : '0);
    seen_nx   = seen_cur | hit;
    first_nx  = (hit && !seen_cur) ? slot_i : first_cur;
  end

  // byte is taken by the framer only in the last slot
  assign scaled = acc_nx >> shift_i;
  assign sat    = (|scaled[ACC_W-1:SUM_W]) ? '1 : scaled[SUM_W-1:0];
  assign byte_o = seen_nx ? {first_nx, sat} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      first_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      acc_q   <= acc_nx;
      first_q <= first_nx;
      seen_q  <= seen_nx;
    end
  end

  // R4: first hit slot is held for the rest of the frame
  a_r4_first_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && slot_i != '0) |=> first_q == $past(first_q));
  // R5: within a frame the sum never shrinks
  a_r5_acc_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i != '0) |=> acc_q >= $past(acc_q));
  // R6: a frame with no hit leaves no slot code behind
  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> first_q == '0);
endmodule

// File: rtl/fcenc_tx.sv
module fcenc_tx #(
  parameter int unsigned N_CH      = 16,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned FRAME_LEN = 8,
  localparam int unsigned LANES  = N_CH / FRAME_LEN,
  localparam int unsigned WORD_W = LANES * BYTE_W,
  localparam int unsigned SLOT_W = $clog2(FRAME_LEN)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [N_CH*BYTE_W-1:0]   bytes_i,
  output logic [WORD_W-1:0]        word_o,
  output logic                     valid_o,
  output logic                     sof_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);

  logic [WORD_W-1:0] words [FRAME_LEN];
  logic [WORD_W-1:0] buf_q [FRAME_LEN];
  logic [SLOT_W-1:0] idx_q;
  logic              act_q;

  for (genvar w = 0; w < FRAME_LEN; w++) begin : g_split
    assign words[w] = bytes_i[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < FRAME_LEN; w++) buf_q[w] <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      for (int w = 0; w < FRAME_LEN; w++) buf_q[w] <= words[w];
      idx_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (idx_q == LAST) act_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign valid_o = act_q;
  assign sof_o   = act_q && (idx_q == '0);
  assign word_o  = act_q ? buf_q[idx_q] : '0;

  // R2: marker only on a valid word
  a_r2_sof_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> valid_o);
  // R2: every word after the first follows a valid word
  a_r2_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !sof_o) |-> $past(valid_o));
  // R9: a load on the final word restarts the stream at once
  a_r9_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && idx_q == LAST && load_i) |=> sof_o);
endmodule

// File: rtl/fcenc_top.sv
module fcenc_top
  import fcenc_pkg::*;
#(
  parameter int unsigned N_CH      = N_CH_D,
  parameter int unsigned SAMP_W    = SAMP_W_D,
  parameter int unsigned FRAME_LEN = FRAME_LEN_D,
  parameter int unsigned SUM_W     = SUM_W_D,
  localparam int unsigned SLOT_W  = $clog2(FRAME_LEN),
  localparam int unsigned BYTE_W  = SLOT_W + SUM_W,
  localparam int unsigned ACC_W   = SAMP_W + SLOT_W,
  localparam int unsigned SHIFT_W = $clog2(ACC_W),
  localparam int unsigned WORD_W  = (N_CH / FRAME_LEN) * BYTE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sync_i,
  input  logic [N_CH*SAMP_W-1:0]   samp_i,
  input  logic [SAMP_W-1:0]        thr_i,
  input  logic [SHIFT_W-1:0]       shift_i,
  output logic [WORD_W-1:0]        word_o,
  output logic                     valid_o,
  output logic                     sof_o
);
  logic [SLOT_W-1:0]      slot;
  logic                   last;
  logic [N_CH*BYTE_W-1:0] bytes;

  fcenc_slot_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
    .clk_i, .rst_ni, .sync_i,
    .slot_o(slot), .last_o(last)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    fcenc_chan #(.SAMP_W(SAMP_W), .SLOT_W(SLOT_W), .SUM_W(SUM_W)) u_ch (
      .clk_i, .rst_ni,
      .slot_i (slot),
      .samp_i (samp_i[c*SAMP_W +: SAMP_W]),
      .thr_i,
      .shift_i,
      .byte_o (bytes[c*BYTE_W +: BYTE_W])
    );
  end

  fcenc_tx #(.N_CH(N_CH), .BYTE_W(BYTE_W), .FRAME_LEN(FRAME_LEN)) u_tx (
    .clk_i, .rst_ni,
    .load_i (last),
    .bytes_i(bytes),
    .word_o, .valid_o, .sof_o
  );
endmodule

// File: tb/sim_fcenc_top.sv
`timescale 1ns/1ps
module sim_fcenc_top;
  localparam int CLK_PERIOD = 4;
  localparam int NCH = 16;
  localparam int NV  = 12;
  localparam int NEMIT = 11;

  typedef struct packed {
    logic [3:0]  ch;
    logic [2:0]  first;
    logic [3:0]  n;
    logic [11:0] amp;
    logic [3:0]  shift;
    logic        sync;
    logic [3:0]  len;
    logic [7:0]  exp;
  } vec_t;

  // ch, first slot, hit count, amplitude, shift, sync, cycles driven, expected byte
  localparam vec_t VEC [NV] = '{
    '{4'd0,  3'd0, 4'd1, 12'd200,  4'd4,  1'b1, 4'd8, 8'h0C}, // R1 R4 slot 0
    '{4'd5,  3'd3, 4'd2, 12'd160,  4'd4,  1'b0, 4'd8, 8'h74}, // R4 first of two
    '{4'd10, 3'd7, 4'd1, 12'd4095, 4'd4,  1'b0, 4'd8, 8'hFF}, // R5 clip, last slot
    '{4'd15, 3'd2, 4'd4, 12'd1000, 4'd8,  1'b0, 4'd8, 8'h4F}, // R5 shift 8
    '{4'd4,  3'd5, 4'd3, 12'd101,  4'd0,  1'b0, 4'd8, 8'hBF}, // R5 no shift, clip
    '{4'd9,  3'd1, 4'd1, 12'd101,  4'd7,  1'b0, 4'd8, 8'h20}, // R3 code kept, sum 0
    '{4'd14, 3'd4, 4'd2, 12'd100,  4'd0,  1'b0, 4'd8, 8'h00}, // R6 equal threshold
    '{4'd3,  3'd6, 4'd2, 12'd2048, 4'd11, 1'b0, 4'd8, 8'hC2}, // R5 shift 11
    '{4'd7,  3'd0, 4'd3, 12'd500,  4'd4,  1'b0, 4'd4, 8'h00}, // R7 cut short
    '{4'd7,  3'd0, 4'd1, 12'd300,  4'd4,  1'b1, 4'd8, 8'h12}, // R7 new slot 0
    '{4'd8,  3'd0, 4'd8, 12'd300,  4'd8,  1'b1, 4'd8, 8'h09}, // R9 hit every slot
    '{4'd0,  3'd0, 4'd0, 12'd0,    4'd0,  1'b0, 4'd8, 8'h00}  // R6 empty frame
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic [NCH*12-1:0] samp = '0;
  logic [11:0] thr = 12'd100;
  logic [3:0]  shift = '0;
  logic [15:0] word;
  logic        valid, sof;

  int total = 0, bad = 0;
  bit mon_on = 0, started = 0, done = 0;
  int widx = 0, fidx = 0;
  logic [15:0] got [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  fcenc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .samp_i(samp),
    .thr_i(thr), .shift_i(shift),
    .word_o(word), .valid_o(valid), .sof_o(sof)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int vec_of(int k);
    int cnt = 0;
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].len == 4'd8) begin
        if (cnt == k) return v;
        cnt++;
      end
    end
    return -1;
  endfunction

  function automatic logic [7:0] exp_byte(int k, int c);
    int v = vec_of(k);
    if (v < 0) return 8'h00;
    return (int'(VEC[v].ch) == c) ? VEC[v].exp : 8'h00;
  endfunction

  task automatic check_frame(int k);
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] b = got[c/2][(c%2)*8 +: 8];
      logic [7:0] e = exp_byte(k, c);
      if (e != 8'h00) chk(b == e, "R3 R4 R5 R7 target byte", b, e);
      else            chk(b == e, "R6 idle byte", b, e);
    end
  endtask

  // R2 R9 monitor: words collected on the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (valid) begin
        if (sof) begin
          if (started && widx != 8) chk(0, "R2 early marker", widx, 8);
          widx = 0;
          started = 1;
        end
        if (started) begin
          if (widx == 8) chk(0, "R2 word without marker", widx, 0);
          else begin
            got[widx] = word;
            widx++;
            if (widx == 8) begin
              check_frame(fidx);
              fidx++;
            end
          end
        end
      end else if (started && widx != 0 && widx != 8) begin
        chk(0, "R2 gap in frame", widx, 8);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R8 valid in reset", valid, 0);
    chk(sof == 1'b0,   "R8 sof in reset", sof, 0);
    chk(word == 16'h0, "R8 word in reset", word, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table walk; frames run back to back (R1 R9)
    for (int v = 0; v < NV; v++) begin
      for (int s = 0; s < int'(VEC[v].len); s++) begin
        @(negedge clk);
        sync  = VEC[v].sync && (s == 0);
        shift = VEC[v].shift;
        samp  = '0;
        if (s >= int'(VEC[v].first) && s < int'(VEC[v].first) + int'(VEC[v].n))
          samp[int'(VEC[v].ch)*12 +: 12] = VEC[v].amp;
        if (v == 0 && s == 3) mon_on = 1;
      end
    end
    @(negedge clk);
    sync = 1'b0;
    samp = '0;
    repeat (12) @(negedge clk);
    // R2 R9: every emitted frame arrived, none for the cut frame (R7)
    chk(fidx >= NEMIT, "R2 R9 frame count", fidx, NEMIT);

    // R8: reset in the middle of a stream of idle frames
    mon_on = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(valid == 1'b0, "R8 valid after mid reset", valid, 0);
    chk(sof == 1'b0,   "R8 sof after mid reset", sof, 0);
    chk(word == 16'h0, "R8 word after mid reset", word, 0);
    repeat (2) @(negedge clk);
    chk(valid == 1'b0, "R8 valid held in reset", valid, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule